// File: doc/BRIEF.md
# I2C Block-Transfer Register Slave

This block is an I2C target that exposes a bank of configuration bytes to an external bus master through a block-style transfer protocol. A write transfer carries two leading bytes, a command code and a byte count, which the target acknowledges and then throws away. Every byte after those two is stored in the bank, starting at index 0 and moving up by one per byte.

A read transfer works the other way. The target first sends the size of the bank as a count byte. It then sends the bank contents from index 0 upward, until the master declines a byte with a not-acknowledge. The bank is presented in parallel on a flat output bus, so that neighbouring logic can use the configuration directly.

SCL and SDA are sampled on the system clock behind a two-flop synchronizer. START and STOP conditions are recognised as SDA edges while SCL is high. The target never drives SDA high: a single output requests that the pad pull the line low. Clock stretching, 10-bit addressing and high-speed mode are not provided.

Top module: `blk_i2c_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and every byte of `cfg_o` is 8'h00.
- R2: The target acknowledges an address byte (SDA pulled low during the ninth SCL pulse) only when bits [7:1] equal `DEV_ADDR`. For any other address it does not acknowledge, and it ignores all traffic until the next START.
- R3: In a write (address bit 0 = 0), the first two bytes after the address are acknowledged and have no effect. Byte k after them is acknowledged and stored at index k, which appears on `cfg_o[8k+7:8k]`.
- R4: Data bytes written beyond index NREG-1 are acknowledged and discarded, and the stored bank is left unchanged.
- R5: In a read (address bit 0 = 1), the first byte sent is NREG. It is followed by bank bytes 0, 1, 2, … in turn, each sent MSB first.
- R6: A read byte requested beyond index NREG-1 is returned as 8'h00.
- R7: When the master does not acknowledge a read byte, the target releases SDA and stays released until the next START.
- R8: A STOP at any point, including in the middle of a byte, returns the target to idle, and a partly received byte is not stored.
- R9: A START in the middle of a transfer abandons that transfer and begins a fresh address phase, which may select the other direction.
- R10: `sda_pull_o` changes only in the cycle after a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_pull_o | output | 1 | 1 requests the pad to pull SDA low |
| cfg_o | output | NREG*8 | Bank contents, byte k at bits [8k+7:8k] |

## Verification
A wrong phase or byte-role state shows up within one byte time: the acknowledge bit sampled by the master comes back wrong, or a command or count byte lands in `cfg_o[7:0]`. A pointer that starts or advances wrongly shifts every stored or returned byte by one index, and that is visible as soon as the bank is read back through the read protocol. A stale transmit state after a not-acknowledge, STOP or repeated START either holds SDA low when the master expects it free, or corrupts the count byte of the next transfer.

// File: rtl/blk_i2c_pkg.sv
package blk_i2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } role_t;

  // Role of the byte that follows a byte with role r in a write transfer.
  function automatic role_t role_after(role_t r);
    case (r)
      RL_ADDR: return RL_CMD;
      RL_CMD:  return RL_CNT;
      default: return RL_DATA;
    endcase
  endfunction

  // True when the received address byte selects this target.
  function automatic logic addr_hit(logic [7:0] b, logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Saturating index step; stops at lim so it never wraps.
  function automatic int unsigned idx_step(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/blk_i2c_lines.sv
module blk_i2c_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);

  // [0],[1] synchronizer; [2] previous synchronized value
  logic [2:0] scl_sh;
  logic [2:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign sda_s      = sda_sh[1];
  assign scl_rise   = scl_sh[1] & ~scl_sh[2];
  assign scl_fall   = ~scl_sh[1] & scl_sh[2];
  assign cond_start = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  assign cond_stop  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];

endmodule

// File: rtl/blk_i2c_regbank.sv
module blk_i2c_regbank #(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] flat
);

  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= 8'h00;
      else if (wr_en && wr_idx == IW'(g))
        regs[g] <= wr_data;
    end
    assign flat[g*8 +: 8] = regs[g];
  end

  // Indices past the bank read as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = regs[i];
  end

endmodule

// File: rtl/blk_i2c_slave.sv
module blk_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int         NREG     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] cfg_o
);
  import blk_i2c_pkg::*;

  localparam int         IW       = $clog2(NREG + 1);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);
  localparam logic [IW-1:0] PTR_END = IW'(NREG);

  // line events
  logic sda_s, ev_scl_rise, ev_scl_fall, ev_start, ev_stop;

  blk_i2c_lines u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s      (sda_s),
    .scl_rise   (ev_scl_rise),
    .scl_fall   (ev_scl_fall),
    .cond_start (ev_start),
    .cond_stop  (ev_stop)
  );

  phase_t        ph;
  role_t         role;
  logic [7:0]    sh;
  logic [3:0]    bcnt;
  logic          rd_mode;
  logic          nack_seen;
  logic [IW-1:0] ptr;
  logic          pull;

  logic          wr_en;
  logic [7:0]    rd_data;
  logic          byte_full;

  assign byte_full = (bcnt == 4'd8);

  // named events for the checker
  logic st_idle, st_addr0, st_mack;
  assign st_idle  = (ph == PH_IDLE);
  assign st_addr0 = (ph == PH_RX) && (role == RL_ADDR) && (bcnt == 4'd0);
  assign st_mack  = (ph == PH_MACK);

  assign wr_en = (ph == PH_RX) && ev_scl_fall && byte_full &&
                 (role == RL_DATA) && (ptr != PTR_END) && !ev_start && !ev_stop;

  blk_i2c_regbank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (ptr),
    .wr_data (sh),
    .rd_idx  (ptr),
    .rd_data (rd_data),
    .flat    (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      role      <= RL_ADDR;
      sh        <= 8'h00;
      bcnt      <= 4'd0;
      rd_mode   <= 1'b0;
      nack_seen <= 1'b0;
      ptr       <= '0;
      pull      <= 1'b0;
    end else if (ev_start) begin
      ph   <= PH_RX;
      role <= RL_ADDR;
      bcnt <= 4'd0;
      pull <= 1'b0;
    end else if (ev_stop) begin
      ph   <= PH_IDLE;
      pull <= 1'b0;
    end else begin
      case (ph)
        PH_RX: begin
          if (ev_scl_rise && !byte_full) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (ev_scl_fall && byte_full) begin
            if (role == RL_ADDR && !addr_hit(sh, DEV_ADDR)) begin
              ph <= PH_IDLE;
            end else begin
              ph   <= PH_ACK;
              pull <= 1'b1;
              if (role == RL_ADDR) begin
                rd_mode <= sh[0];
                ptr     <= '0;
              end
              if (role == RL_DATA)
                ptr <= IW'(idx_step(int'(ptr), NREG));
            end
          end
        end
        PH_ACK: begin
          if (ev_scl_fall) begin
            bcnt <= 4'd0;
            if (role == RL_ADDR && rd_mode) begin
              ph   <= PH_TX;
              sh   <= CNT_BYTE;
              pull <= ~CNT_BYTE[7];
            end else begin
              ph   <= PH_RX;
              role <= role_after(role);
              pull <= 1'b0;
            end
          end
        end
        PH_TX: begin
          if (ev_scl_fall) begin
            if (bcnt == 4'd7) begin
              ph   <= PH_MACK;
              pull <= 1'b0;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              pull <= ~sh[6];
              bcnt <= bcnt + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (ev_scl_rise) nack_seen <= sda_s;
          if (ev_scl_fall) begin
            if (nack_seen) begin
              ph <= PH_IDLE;
            end else begin
              ph   <= PH_TX;
              sh   <= rd_data;
              pull <= ~rd_data[7];
              bcnt <= 4'd0;
              ptr  <= IW'(idx_step(int'(ptr), NREG));
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;

endmodule

// File: rtl/blk_i2c_chk.sv
module blk_i2c_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic ev_scl_fall,
  input logic ev_start,
  input logic ev_stop,
  input logic st_idle,
  input logic st_addr0,
  input logic st_mack,
  input logic nack_seen,
  input logic wr_en,
  input logic rd_mode
);

  AST_PULL_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(ev_scl_fall || ev_start || ev_stop)); // R10

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (st_idle && !sda_pull)); // R8

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st_addr0 && !sda_pull)); // R9

  AST_NACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mack && ev_scl_fall && nack_seen) |=> (st_idle && !sda_pull)); // R7

  AST_NO_STORE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode); // R3

endmodule

bind blk_i2c_slave blk_i2c_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull    (sda_pull_o),
  .ev_scl_fall (ev_scl_fall),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .st_idle     (st_idle),
  .st_addr0    (st_addr0),
  .st_mack     (st_mack),
  .nack_seen   (nack_seen),
  .wr_en       (wr_en),
  .rd_mode     (rd_mode)
);

// File: tb/tb_blk_i2c_slave.sv
module tb_blk_i2c_slave;

  localparam logic [6:0] DEV  = 7'h52;
  localparam int         NREG = 16;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] cfg;
  wire  sda_line = m_sda & ~sda_pull;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  blk_i2c_slave #(.DEV_ADDR(DEV), .NREG(NREG)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .cfg_o      (cfg)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29) + 11);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qtr();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qtr();
    m_scl = 1'b1; qtr();
    m_sda = 1'b0; qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qtr();
    m_scl = 1'b1; qtr();
    m_sda = 1'b1; qtr();
  endtask

  task automatic send_bit(logic b);
    m_sda = b; qtr();
    m_scl = 1'b1; qtr(); qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; qtr();
    m_scl = 1'b1; qtr();
    ack = sda_line; qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic rd_byte(logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qtr();
      m_scl = 1'b1; qtr();
      b = {b[6:0], sda_line}; qtr();
      m_scl = 1'b0; qtr();
    end
    m_sda = nack; qtr();
    m_scl = 1'b1; qtr(); qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    chk("R1 pull after reset", 32'(sda_pull), 0);
    chk("R1 bank after reset", 32'(cfg == '0), 1);
    rst_n = 1'b1;
    qtr();

    // R2: sweep all addresses, write direction
    for (int ad = 0; ad < 128; ad++) begin
      i2c_start();
      wr_byte({7'(ad), 1'b0}, a);
      chk($sformatf("R2 addr %0h ack", ad), 32'(a), (7'(ad) == DEV) ? 0 : 1);
      i2c_stop();
    end

    // R3/R4: full write with two ignored bytes and two extra bytes
    i2c_start();
    wr_byte({DEV, 1'b0}, a); chk("R2 write addr ack", 32'(a), 0);
    wr_byte(8'hC3, a);       chk("R3 cmd byte ack", 32'(a), 0);
    wr_byte(8'h5A, a);       chk("R3 count byte ack", 32'(a), 0);
    for (int i = 0; i < NREG + 2; i++) begin
      wr_byte((i < NREG) ? pat(i) : 8'hEE, a);
      chk(i < NREG ? "R3 data ack" : "R4 overflow ack", 32'(a), 0);
    end
    i2c_stop();
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R3 stored byte %0d", i), 32'(cfg[i*8 +: 8]), 32'(pat(i)));
    chk("R4 last byte kept", 32'(cfg[(NREG-1)*8 +: 8]), 32'(pat(NREG-1)));

    // R5/R6/R7: read back with count prefix, one past the end, NACK
    i2c_start();
    wr_byte({DEV, 1'b1}, a); chk("R2 read addr ack", 32'(a), 0);
    rd_byte(1'b0, d);        chk("R5 count byte", 32'(d), NREG);
    for (int i = 0; i < NREG; i++) begin
      rd_byte(1'b0, d);
      chk($sformatf("R5 read byte %0d", i), 32'(d), 32'(pat(i)));
    end
    rd_byte(1'b1, d);        chk("R6 past end reads zero", 32'(d), 0);
    qtr(); qtr();
    chk("R7 released after nack", 32'(sda_pull), 0);
    m_scl = 1'b1; qtr(); qtr();
    chk("R7 line free after nack", 32'(sda_line), 1);
    m_scl = 1'b0; qtr();
    i2c_stop();

    // R2: foreign address followed by bytes is ignored
    i2c_start();
    wr_byte({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign addr nack", 32'(a), 1);
    for (int i = 0; i < 3; i++) begin
      wr_byte(8'h77, a); chk("R2 ignored byte nack", 32'(a), 1);
    end
    i2c_stop();
    chk("R2 bank untouched", 32'(cfg[7:0]), 32'(pat(0)));

    // R8: STOP in the middle of a data byte
    i2c_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h01, a);
    wr_byte(8'h02, a);
    wr_byte(8'hA5, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    qtr();
    chk("R8 byte0 written", 32'(cfg[7:0]), 32'hA5);
    chk("R8 partial byte dropped", 32'(cfg[15:8]), 32'(pat(1)));
    chk("R8 idle released", 32'(sda_pull), 0);

    // R9: repeated START mid-byte switches to a read
    i2c_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h10, a);
    wr_byte(8'h20, a);
    wr_byte(8'h3C, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    i2c_start();
    wr_byte({DEV, 1'b1}, a); chk("R9 restart addr ack", 32'(a), 0);
    rd_byte(1'b0, d);        chk("R9 count after restart", 32'(d), NREG);
    rd_byte(1'b0, d);        chk("R9 byte0 after restart", 32'(d), 32'h3C);
    rd_byte(1'b1, d);        chk("R8 byte1 not overwritten", 32'(d), 32'(pat(1)));
    i2c_stop();

    // R10: a second write after all that still lands at index 0
    i2c_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'hFF, a);
    wr_byte(8'hFF, a);
    wr_byte(8'h96, a); chk("R10 data ack after recovery", 32'(a), 0);
    i2c_stop();
    chk("R10 byte0 after recovery", 32'(cfg[7:0]), 32'h96);

    finish_run();
  end

endmodule